// File: doc/BRIEF.md
# Serial Memory Transaction Sequencer

This block is the host-side controller that performs one complete transfer with a single-wire serial bit memory of 256 cells. A separate slot engine produces the analogue timing of each bit slot on the wire. This sequencer only decides which slot comes next and keeps count of them. A transfer always has three parts, in this order:

1. A run of write-zero slots. This pushes the device's address pointer to its top value, where it stays locked, so the device is in a known state.
2. An eight-bit command byte, sent with write slots.
3. A fixed number of data slots. For a read these are read slots, and the returned bits are collected into a register. For a write these are write slots, and they carry bits taken from a register.

The requester starts a transfer with a one-cycle `start` pulse, together with the operation flag and, for a write, the data word. `busy` is high while the transfer runs. `done` pulses once at the end. A transfer cannot be aborted or restarted partway through.

Slot requests leave the block on a valid/ready channel. While `slot_req_valid` is high and `slot_req_ready` is low, the request is held unchanged: the kind does not change and valid does not drop. The request counts as issued in the cycle where valid and ready are both high. The sequencer then lowers valid and waits for a one-cycle `slot_done` from the engine, which carries the sampled bit on `slot_rd_bit` when the slot was a read. Only one slot is ever outstanding. A `slot_done` that arrives with no slot outstanding is ignored. Slot kind codes are: 2'b00 write-zero, 2'b01 write-one, 2'b10 read.

Top module: `smem_xact_seq`

## Requirements
- R1: After reset, `busy`, `done` and `slot_req_valid` are 0 and `rd_data` is all zeros.
- R2: A `start` sampled while idle raises `busy` in the next cycle. The first SYNC_SLOTS slots requested are all write-zero (code 2'b00).
- R3: The next eight slots carry the command byte, least significant bit first: write-one, then two write-zero slots (select value 00), then five write-one slots for a write or five write-zero slots for a read.
- R4: Exactly DATA_BITS data slots follow the command. For a write, slot i is write-one when `wr_data[i]` is 1 and write-zero otherwise, starting at i=0. For a read, every data slot is a read slot (code 2'b10).
- R5: On a read, the bit returned by data slot i ends up in `rd_data[i]`, so the first bit received is in bit 0. `rd_data` keeps that value after the transfer.
- R6: A write transfer leaves `rd_data` unchanged.
- R7: A `start` while `busy` is ignored: no slot is added or altered and the transfer in progress completes. Changes to `wr_data` or `op_write` after the accepted start have no effect.
- R8: `done` is high for exactly one cycle: the cycle after the final data slot's `slot_done` is sampled. `busy` is low in that same cycle.
- R9: While `slot_req_valid` is high and `slot_req_ready` is low, valid stays high and `slot_req_kind` stays stable. After a handshake, valid stays low until `slot_done` is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transfer request pulse |
| op_write | input | 1 | 1 = write transfer, 0 = read transfer |
| wr_data | input | DATA_BITS | Data to write, bit 0 sent first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | DATA_BITS | Collected read data, bit 0 received first |
| slot_req_valid | output | 1 | Slot request valid |
| slot_req_ready | input | 1 | Slot engine accepts the request |
| slot_req_kind | output | 2 | 00 write-zero, 01 write-one, 10 read |
| slot_done | input | 1 | Outstanding slot has completed |
| slot_rd_bit | input | 1 | Bit sampled in a read slot |

## Verification
The bench builds the block with its default parameters: 264 synchronising slots, 256 data bits and a five-bit operation field. Every transfer is therefore the full 528-slot frame. This exercises the slot counter at its widest terminal counts, in all three phases. The slot engine model inserts random back-pressure and random completion delays. This puts the hold rules and the single-outstanding rule to work under many timings. A start pulse and a changed data word are injected mid-transfer, which shows that the captured operation and data are the ones used.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;
  typedef enum logic [1:0] {
    SLOT_W0 = 2'b00,
    SLOT_W1 = 2'b01,
    SLOT_RD = 2'b10
  } slot_kind_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_SYNC = 2'b01,
    PH_CMD  = 2'b10,
    PH_DATA = 2'b11
  } phase_t;
endpackage

// File: rtl/smem_seq_ctrl.sv
module smem_seq_ctrl
  import smem_seq_pkg::*;
#(
  parameter int SYNC_SLOTS = 264,
  parameter int CMD_SLOTS  = 8,
  parameter int DATA_BITS  = 256
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   op_write,
  input  logic   req_ready,
  input  logic   slot_done,
  output logic   req_valid,
  output logic   load,
  output logic   slot_fin,
  output logic   op_q,
  output phase_t phase,
  output logic   busy,
  output logic   done
);
  localparam int MAXL = (SYNC_SLOTS > DATA_BITS) ?
                        ((SYNC_SLOTS > CMD_SLOTS) ? SYNC_SLOTS : CMD_SLOTS) :
                        ((DATA_BITS > CMD_SLOTS) ? DATA_BITS : CMD_SLOTS);
  localparam int CW = $clog2(MAXL + 1);

  phase_t        phase_q;
  logic          wait_q;
  logic          done_q;
  logic          op_r;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic          at_last;

  always_comb begin
    case (phase_q)
      PH_SYNC: last_idx = CW'(SYNC_SLOTS - 1);
      PH_CMD:  last_idx = CW'(CMD_SLOTS - 1);
      PH_DATA: last_idx = CW'(DATA_BITS - 1);
      default: last_idx = '0;
    endcase
  end

  assign at_last   = (cnt_q == last_idx);
  assign load      = start && (phase_q == PH_IDLE);
  assign req_valid = (phase_q != PH_IDLE) && !wait_q;
  assign slot_fin  = wait_q && slot_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wait_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      op_r    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        phase_q <= PH_SYNC;
        cnt_q   <= '0;
        wait_q  <= 1'b0;
        op_r    <= op_write;
      end else if (req_valid && req_ready) begin
        wait_q <= 1'b1;
      end else if (slot_fin) begin
        wait_q <= 1'b0;
        if (at_last) begin
          cnt_q <= '0;
          case (phase_q)
            PH_SYNC: phase_q <= PH_CMD;
            PH_CMD:  phase_q <= PH_DATA;
            default: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;
  assign op_q  = op_r;

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !slot_fin) |=> busy);
  assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
endmodule

// File: rtl/smem_cmd_shifter.sv
module smem_cmd_shifter
  import smem_seq_pkg::*;
#(
  parameter int         SEL_W     = 2,
  parameter logic [1:0] SEL_VALUE = 2'b00,
  parameter int         OP_BITS   = 5,
  localparam int        CMD_W     = 1 + SEL_W + OP_BITS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   op_write,
  input  logic   slot_fin,
  input  phase_t phase,
  output logic   cmd_bit
);
  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] cmd_init;
  logic [OP_BITS-1:0] op_field;

  for (genvar g = 0; g < OP_BITS; g++) begin : g_op
    assign op_field[g] = op_write;
  end

  assign cmd_init = {op_field, SEL_VALUE[SEL_W-1:0], 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (load) begin
      cmd_q <= cmd_init;
    end else if (slot_fin && phase == PH_CMD) begin
      cmd_q <= {1'b0, cmd_q[CMD_W-1:1]};
    end
  end

  assign cmd_bit = cmd_q[0];

  assert_cmd_lead_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_SYNC && phase == PH_CMD) |-> cmd_bit);
endmodule

// File: rtl/smem_data_path.sv
module smem_data_path
  import smem_seq_pkg::*;
#(
  parameter int DATA_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 op_q,
  input  logic                 slot_fin,
  input  logic                 rd_bit,
  input  phase_t               phase,
  output logic                 wr_bit,
  output logic [DATA_BITS-1:0] rd_data
);
  logic [DATA_BITS-1:0] wr_q;
  logic [DATA_BITS-1:0] rd_q;
  logic                 data_step;

  assign data_step = slot_fin && (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (load) begin
      wr_q <= wr_data;
    end else if (data_step && op_q) begin
      wr_q <= {1'b0, wr_q[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (data_step && !op_q) begin
      rd_q <= {rd_bit, rd_q[DATA_BITS-1:1]};
    end
  end

  assign wr_bit  = wr_q[0];
  assign rd_data = rd_q;

  assert_write_keeps_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && op_q) |=> $stable(rd_data));
  assert_idle_keeps_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> $stable(rd_data));
endmodule

// File: rtl/smem_xact_seq.sv
module smem_xact_seq
  import smem_seq_pkg::*;
#(
  parameter int         SYNC_SLOTS = 264,
  parameter int         DATA_BITS  = 256,
  parameter int         OP_BITS    = 5,
  parameter int         SEL_W      = 2,
  parameter logic [1:0] SEL_VALUE  = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 op_write,
  input  logic [DATA_BITS-1:0] wr_data,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 slot_req_valid,
  input  logic                 slot_req_ready,
  output logic [1:0]           slot_req_kind,
  input  logic                 slot_done,
  input  logic                 slot_rd_bit
);
  localparam int CMD_SLOTS = 1 + SEL_W + OP_BITS;

  phase_t     phase;
  logic       load;
  logic       slot_fin;
  logic       op_q;
  logic       cmd_bit;
  logic       wr_bit;
  slot_kind_t kind;

  smem_seq_ctrl #(
    .SYNC_SLOTS(SYNC_SLOTS),
    .CMD_SLOTS (CMD_SLOTS),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_write (op_write),
    .req_ready(slot_req_ready),
    .slot_done(slot_done),
    .req_valid(slot_req_valid),
    .load     (load),
    .slot_fin (slot_fin),
    .op_q     (op_q),
    .phase    (phase),
    .busy     (busy),
    .done     (done)
  );

  smem_cmd_shifter #(
    .SEL_W    (SEL_W),
    .SEL_VALUE(SEL_VALUE),
    .OP_BITS  (OP_BITS)
  ) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .op_write(op_write),
    .slot_fin(slot_fin),
    .phase   (phase),
    .cmd_bit (cmd_bit)
  );

  smem_data_path #(
    .DATA_BITS(DATA_BITS)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .wr_data (wr_data),
    .op_q    (op_q),
    .slot_fin(slot_fin),
    .rd_bit  (slot_rd_bit),
    .phase   (phase),
    .wr_bit  (wr_bit),
    .rd_data (rd_data)
  );

  always_comb begin
    case (phase)
      PH_CMD:  kind = cmd_bit ? SLOT_W1 : SLOT_W0;
      PH_DATA: kind = op_q ? (wr_bit ? SLOT_W1 : SLOT_W0) : SLOT_RD;
      default: kind = SLOT_W0;
    endcase
  end

  assign slot_req_kind = kind;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_valid && !slot_req_ready) |=> (slot_req_valid && $stable(slot_req_kind)));
  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid |-> (slot_req_kind != 2'b11));
endmodule

// File: tb/tb_smem_xact_seq.sv
module tb_smem_xact_seq;
  localparam int SYNC = 264;
  localparam int DW   = 256;
  localparam int CMDN = 8;
  localparam int SEQ  = SYNC + CMDN + DW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic          op_write = 0;
  logic [DW-1:0] wr_data = '0;
  logic          busy, done, slot_req_valid;
  logic [DW-1:0] rd_data;
  logic          slot_req_ready = 0;
  logic [1:0]    slot_req_kind;
  logic          slot_done = 0;
  logic          slot_rd_bit = 0;

  smem_xact_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data),
    .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
    .slot_req_kind(slot_req_kind), .slot_done(slot_done),
    .slot_rd_bit(slot_rd_bit)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_fin_cyc = 0;
  int log_n  = 0;
  int rd_idx = 0;
  int r9_bad = 0;
  logic [1:0]    log_k [SEQ+16];
  logic [1:0]    exp_k [SEQ];
  logic [DW-1:0] dev_bits = '0;
  logic [DW-1:0] model_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW / 32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic build_expected(input logic op, input logic [DW-1:0] d);
    for (int i = 0; i < SYNC; i++) exp_k[i] = 2'b00;
    exp_k[SYNC]     = 2'b01;
    exp_k[SYNC + 1] = 2'b00;
    exp_k[SYNC + 2] = 2'b00;
    for (int i = 3; i < CMDN; i++) exp_k[SYNC + i] = op ? 2'b01 : 2'b00;
    for (int i = 0; i < DW; i++)
      exp_k[SYNC + CMDN + i] = op ? {1'b0, d[i]} : 2'b10;
  endtask

  task automatic check_segment(input string req, input int lo, input int hi);
    int bad = 0;
    int first = -1;
    for (int i = lo; i < hi; i++) begin
      if (log_k[i] !== exp_k[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first >= 0)
      $display("segment %s first mismatch at slot %0d kind=%0d want=%0d",
               req, first, log_k[first], exp_k[first]);
    check(req, DW'(bad), '0);
  endtask

  // slot engine model with random back-pressure and completion delay
  initial begin
    forever begin
      @(negedge clk);
      if (slot_req_valid) begin
        logic [1:0] k;
        k = slot_req_kind;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (!slot_req_valid || slot_req_kind !== k) r9_bad++;
        end
        slot_req_ready = 1;
        @(negedge clk);
        slot_req_ready = 0;
        if (slot_req_valid) r9_bad++;
        if (log_n < SEQ + 16) log_k[log_n] = k;
        log_n++;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (slot_req_valid) r9_bad++;
        end
        if (k == 2'b10) begin
          slot_rd_bit = dev_bits[rd_idx];
          rd_idx++;
        end else begin
          slot_rd_bit = $urandom % 2;
        end
        slot_done = 1;
        last_fin_cyc = cyc;
        @(negedge clk);
        slot_done = 0;
      end
    end
  end

  task automatic run_xact(input logic op, input logic [DW-1:0] d, input bit mid_start);
    log_n = 0;
    rd_idx = 0;
    build_expected(op, d);
    @(negedge clk);
    start = 1; op_write = op; wr_data = d;
    @(negedge clk);
    start = 0;
    check("R2 busy after start", DW'(busy), DW'(1));
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1; op_write = ~op; wr_data = ~d;
      @(negedge clk);
      start = 0;
      check("R7 busy kept on ignored start", DW'(busy), DW'(1));
    end
    while (!done) @(negedge clk);
    check("R8 done one cycle after final slot", DW'(cyc), DW'(last_fin_cyc + 1));
    check("R8 busy low with done", DW'(busy), '0);
    @(negedge clk);
    check("R8 done single pulse", DW'(done), '0);
    repeat (20) @(negedge clk);
    check("R4 R7 total slot count", DW'(log_n), DW'(SEQ));
    check_segment("R2 sync slots", 0, SYNC);
    check_segment("R3 command byte", SYNC, SYNC + CMDN);
    check_segment(op ? "R4 write data slots" : "R4 read slots", SYNC + CMDN, SEQ);
    if (op) begin
      dev_bits = d;
      check("R6 rd_data unchanged by write", rd_data, model_rd);
    end else begin
      model_rd = dev_bits;
      check("R5 rd_data bit order", rd_data, model_rd);
    end
    check("R9 request hold and single outstanding", DW'(r9_bad), '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy reset", DW'(busy), '0);
    check("R1 done reset", DW'(done), '0);
    check("R1 valid reset", DW'(slot_req_valid), '0);
    check("R1 rd_data reset", rd_data, '0);
    // directed corners
    run_xact(1'b1, '1, 0);
    run_xact(1'b0, '0, 0);
    run_xact(1'b1, {DW/2{2'b01}}, 0);
    run_xact(1'b0, '0, 1);
    run_xact(1'b1, rand_word(), 1);
    run_xact(1'b0, '0, 0);
    // random mix
    for (int t = 0; t < 6; t++) run_xact(1'($urandom % 2), rand_word(), 1'($urandom % 2));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule